// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Pulse Generator

This block produces a single output pulse of programmable length each time a qualified trigger edge is seen. It has two asynchronous trigger inputs of opposite sense. One starts a pulse on a high-to-low transition and the other on a low-to-high transition. Each input also acts as the enable for the other. A counter clocked by the system clock sets the pulse length, given as a cycle count on a width input. Both triggers are brought into the clock domain by a two-flop synchroniser. Edges are then found by comparing each synchronised level with its value one cycle earlier.

The block drives a true pulse output and a separate complementary output. Once a pulse has started, it runs its full length no matter what the triggers do. An active-low reset overrides everything: it ends a pulse at once and discards any trigger activity seen while it is held. A second channel is simply a second instance.

The controller has two states. IDLE has the output low and waits for a trigger. ACTIVE has the output high while the counter runs. The transitions are:
- FIRE: IDLE to ACTIVE, on an accepted trigger edge; the width is captured at this point.
- EXPIRE: ACTIVE to IDLE, when the counter reaches zero.
- ABORT: any state to IDLE, when reset is asserted (asynchronous).

Top module: `os_monostable`

## Requirements
- R1: While rst_n is low, and after its release until a trigger is accepted, pulse_o is 0 and pulse_n_o is 1.
- R2: A high-to-low transition on trig_fall_i while trig_rise_i is high starts a pulse.
- R3: A low-to-high transition on trig_rise_i while trig_fall_i is low starts a pulse.
- R4: A falling edge on trig_fall_i while trig_rise_i is low starts no pulse. A rising edge on trig_rise_i while trig_fall_i is high starts no pulse.
- R5: An input change made between clock edges k and k+1 raises pulse_o after edge k+3. pulse_o then stays high for exactly N cycles, where N is width_i read as an unsigned number. A width of 0 acts as 1.
- R6: While a pulse is active, trigger edges have no effect, including an edge detected in the last active cycle. An edge detected in the first idle cycle after a pulse starts a new pulse, so the output is low for exactly one cycle between the two pulses.
- R7: width_i is captured when a trigger is accepted. A change to it during a pulse affects only the next pulse.
- R8: pulse_n_o is the inverse of pulse_o in every cycle.
- R9: Driving rst_n low ends a pulse in progress at once, without waiting for a clock edge.
- R10: Trigger edges that occur while rst_n is low are not stored. A trigger level that differs after reset release from its level before reset is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, overrides triggering |
| trig_fall_i | input | 1 | Trigger on falling edge; enables trig_rise_i when low |
| trig_rise_i | input | 1 | Trigger on rising edge; enables trig_fall_i when high |
| width_i | input | W | Pulse length in clock cycles (0 acts as 1) |
| pulse_o | output | 1 | True pulse output |
| pulse_n_o | output | 1 | Complementary pulse output |

## Verification
Every width from 0 to 10 is driven through the falling-edge path, and widths 1 to 10 through the rising-edge path. For each, the bench measures the start cycle and the length. This separates an off-by-one in the counter or in the synchroniser depth from a fault in the edge polarity.

The gated cases (falling edge with the other input low, rising edge with the other input high) must give no pulse at all. Second edges placed inside a pulse, in its last cycle and in the first cycle after it separate a retriggerable or late-closing controller from the correct one.

A mid-pulse width change, a mid-pulse reset, and trigger activity during reset show whether the width is captured at FIRE and whether reset clears both the pulse and the synchroniser history.

// File: rtl/os_pulse_pkg.sv
package os_pulse_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } os_state_e;
endpackage

// File: rtl/os_sync_chain.sv
module os_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/os_trig_qualify.sv
module os_trig_qualify #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_raw,
    input  logic rise_raw,
    output logic fire
);
    // One cycle after the synchroniser fills, the previous-value register holds a real sample too.
    localparam int WARM = STAGES + 1;
    localparam int WCW  = $clog2(WARM + 1);

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prev;
    logic [WCW-1:0] warm;
    logic ready;
    logic fall_edge;
    logic rise_edge;

    assign raw = {rise_raw, fall_raw};

    // index 0: falling-edge trigger, index 1: rising-edge trigger
    for (genvar g = 0; g < 2; g++) begin : g_sync
        os_sync_chain #(.STAGES(STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw[g]),
            .q     (cur[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
            warm <= '0;
        end else begin
            prev <= cur;
            if (!ready) begin
                warm <= warm + WCW'(1);
            end
        end
    end

    assign ready     = (warm == WCW'(WARM));
    assign fall_edge = prev[0] & ~cur[0];
    assign rise_edge = ~prev[1] & cur[1];
    // R2/R3/R4: each trigger is enabled by the level of the other
    assign fire = ready & ((fall_edge & cur[1]) | (rise_edge & ~cur[0]));
endmodule

// File: rtl/os_width_timer.sv
module os_width_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] width,
    input  logic         run,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    // R5: a zero width is treated as one cycle
    assign eff = (width == '0) ? W'(1) : width;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= eff - W'(1);   // R7: width captured here only
        end else if (run && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign done = (cnt == '0);

    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

    a_r7_hold_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt));
endmodule

// File: rtl/os_monostable.sv
module os_monostable #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig_fall_i,
    input  logic         trig_rise_i,
    input  logic [W-1:0] width_i,
    output logic         pulse_o,
    output logic         pulse_n_o
);
    import os_pulse_pkg::*;

    os_state_e state;
    os_state_e state_nx;
    logic      fire;
    logic      tmr_done;
    logic      tmr_load;
    logic      q_r;
    logic      qn_r;

    os_trig_qualify #(.STAGES(SYNC_STAGES)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_raw (trig_fall_i),
        .rise_raw (trig_rise_i),
        .fire     (fire)
    );

    assign tmr_load = (state == ST_IDLE) && fire;

    os_width_timer #(.W(W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .width (width_i),
        .run   (state == ST_ACTIVE),
        .done  (tmr_done)
    );

    // next state: FIRE and EXPIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (fire)     state_nx = ST_ACTIVE;  // FIRE
            ST_ACTIVE: if (tmr_done) state_nx = ST_IDLE;    // EXPIRE; triggers ignored (R6)
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // state register; ABORT on reset (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs, registered separately from each other
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r  <= 1'b0;
            qn_r <= 1'b1;
        end else begin
            q_r  <= (state_nx == ST_ACTIVE);
            qn_r <= (state_nx != ST_ACTIVE);
        end
    end

    assign pulse_o   = q_r;
    assign pulse_n_o = qn_r;

    a_r8_complement: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o != pulse_n_o);

    a_r6_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !tmr_done) |=> (state == ST_ACTIVE));

    a_r2_start_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(fire));

    a_r5_end_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_o) |-> $past(tmr_done));
endmodule

// File: tb/test_os_monostable.sv
`timescale 1ns/1ps
module test_os_monostable;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_fall_i = 1'b1;
    logic       trig_rise_i = 1'b0;
    logic [7:0] width_i = 8'd4;
    logic       pulse_o;
    logic       pulse_n_o;

    int n_total = 0;
    int n_pass  = 0;
    int comp_err = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    os_monostable #(.W(8), .SYNC_STAGES(2)) i_os_monostable (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_fall_i (trig_fall_i),
        .trig_rise_i (trig_rise_i),
        .width_i     (width_i),
        .pulse_o     (pulse_o),
        .pulse_n_o   (pulse_n_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    endtask

    // samples at each of the next win falling edges; index 1 is the first
    task automatic observe(input int win, output int first, output int cnt);
        first = -1;
        cnt = 0;
        for (int i = 1; i <= win; i++) begin
            @(negedge clk);
            if (pulse_o === pulse_n_o) comp_err++;
            if (pulse_o === 1'b1) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // levels: fall input high, rise input low; no edge is qualified on the way
    task automatic go_idle();
        @(negedge clk);
        trig_fall_i = 1'b1;
        settle(3);
        trig_rise_i = 1'b0;
        settle(6);
    endtask

    initial begin : main
        int first, cnt, eff;
        // R1: reset state
        settle(3);
        check(pulse_o === 1'b0 && pulse_n_o === 1'b1, "R1 during reset", pulse_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        observe(8, first, cnt);
        check(cnt == 0 && pulse_n_o === 1'b1, "R1 after release", cnt, 0);

        // R2/R5: falling-edge path, widths 0..10
        for (int n = 0; n <= 10; n++) begin
            eff = (n == 0) ? 1 : n;
            width_i = 8'(n);
            trig_rise_i = 1'b1;           // rising edge while fall input high: gated
            settle(5);
            trig_fall_i = 1'b0;
            observe(eff + 8, first, cnt);
            check(first == 3, $sformatf("R5 fall start n=%0d", n), first, 3);
            check(cnt == eff, $sformatf("R2 fall width n=%0d", n), cnt, eff);
            go_idle();
        end

        // R3/R5: rising-edge path, widths 1..10
        for (int n = 1; n <= 10; n++) begin
            width_i = 8'(n);
            trig_fall_i = 1'b0;           // falling edge while rise input low: gated
            settle(5);
            trig_rise_i = 1'b1;
            observe(n + 8, first, cnt);
            check(first == 3, $sformatf("R5 rise start n=%0d", n), first, 3);
            check(cnt == n, $sformatf("R3 rise width n=%0d", n), cnt, n);
            go_idle();
        end

        // R4: gated edges
        width_i = 8'd3;
        trig_fall_i = 1'b0;               // rise input is low
        observe(10, first, cnt);
        check(cnt == 0, "R4 fall edge gated by low rise input", cnt, 0);
        trig_fall_i = 1'b1;
        settle(5);
        trig_rise_i = 1'b1;               // fall input is high
        observe(10, first, cnt);
        check(cnt == 0, "R4 rise edge gated by high fall input", cnt, 0);
        go_idle();

        // R6: a second edge at offset d; n=5 ends after offset 7
        for (int d = 3; d <= 6; d++) begin
            width_i = 8'd5;
            trig_rise_i = 1'b1;
            settle(5);
            trig_fall_i = 1'b0;
            fork
                observe(22, first, cnt);
                begin
                    settle(d - 2);
                    trig_fall_i = 1'b1;
                    settle(2);
                    trig_fall_i = 1'b0;
                end
            join
            eff = (d <= 5) ? 5 : 10;
            check(first == 3 && cnt == eff, $sformatf("R6 second edge d=%0d", d), cnt, eff);
            go_idle();
        end

        // R7: width changed mid-pulse
        width_i = 8'd6;
        trig_rise_i = 1'b1;
        settle(5);
        trig_fall_i = 1'b0;
        fork
            observe(14, first, cnt);
            begin settle(4); width_i = 8'd2; end
        join
        check(cnt == 6, "R7 old width kept", cnt, 6);
        go_idle();
        trig_rise_i = 1'b1;
        settle(5);
        trig_fall_i = 1'b0;
        observe(10, first, cnt);
        check(cnt == 2, "R7 new width on next pulse", cnt, 2);
        go_idle();

        // R9: reset cuts a pulse short
        width_i = 8'd20;
        trig_rise_i = 1'b1;
        settle(5);
        trig_fall_i = 1'b0;
        settle(6);
        check(pulse_o === 1'b1, "R9 pulse running", pulse_o, 1);
        #1 rst_n = 1'b0;
        #0.5;
        check(pulse_o === 1'b0 && pulse_n_o === 1'b1, "R9 immediate end", pulse_o, 0);

        // R10: edges during reset are dropped
        @(negedge clk);
        trig_fall_i = 1'b1;
        settle(3);
        trig_fall_i = 1'b0;
        settle(3);
        trig_fall_i = 1'b1;
        settle(2);
        trig_fall_i = 1'b0;               // left low across release
        rst_n = 1'b1;
        observe(12, first, cnt);
        check(cnt == 0, "R10 no pulse after release", cnt, 0);
        go_idle();

        check(comp_err == 0, "R8 complement", comp_err, 0);
        done_flag = 1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_total++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end
endmodule